// File: doc/BRIEF.md
# Dual-Target Serial Synthesizer Programmer

This block loads 24-bit control words into one of two external frequency-synthesis devices, an IF converter and an RF synthesizer. Both devices hang on one shared serial data line and one shared serial clock. Each device has its own load-enable line. A host hands over a word and a target select through a valid/ready command port. The block then shifts the word out most significant bit first. It holds the chosen device's enable high for the whole transfer, and it pulses `done` when the transfer has finished.

The serial clock is derived from the system clock. Each low phase and each high phase lasts `HALF_CYC` system cycles. New data is launched as the serial clock falls, and the devices sample it as the clock rises. Before the first rising edge the first bit has a full low phase to settle.

The command port accepts a command only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for the whole transfer, which applies back-pressure to the host. A request presented while `cmd_ready` is low is not captured. If the host keeps `cmd_valid` high, the request is taken in the first cycle `cmd_ready` returns, and that cycle is the `done` cycle.

Top module: `dual_synth_loader`

## Requirements
- R1: Every transfer produces exactly 24 rising edges of `ser_clk`, and `ser_data` sampled at those edges gives the accepted `cmd_word`, bit 23 first and bit 0 last.
- R2: `ser_data` changes only in the cycle in which `ser_clk` falls, or in the cycle in which a transfer starts and presents bit 23.
- R3: After reset `ser_clk`, `ser_data`, both enables, `busy` and `done` are 0 and `cmd_ready` is 1. Whenever both enables are low, `ser_clk` and `ser_data` are 0.
- R4: `cmd_target` = 0 selects `tgt_if_en` and `cmd_target` = 1 selects `tgt_rf_en`. Only the selected enable goes high. It rises in the cycle after acceptance and stays constant until the transfer ends.
- R5: Each low phase and each high phase of `ser_clk` lasts exactly `HALF_CYC` system cycles. The first rising edge comes `HALF_CYC` cycles after the enable rises.
- R6: The enable falls exactly 2·`HALF_CYC` cycles after the last rising edge of `ser_clk`: one high phase plus one low tail phase.
- R7: `done` is high for exactly one cycle. That is the cycle in which the enable is first low and `busy` is low.
- R8: `cmd_ready` equals the inverse of `busy`. A request presented while busy starts no transfer and does not alter the transfer in progress.
- R9: A command held valid across a transfer is accepted in the `done` cycle, and the next enable rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word and target are valid |
| cmd_ready | output | 1 | Block can accept a command (idle) |
| cmd_word | input | 24 | Control word to send |
| cmd_target | input | 1 | 0 = IF device, 1 = RF synthesizer |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, launched on the falling edge |
| tgt_if_en | output | 1 | Load enable for the IF device |
| tgt_rf_en | output | 1 | Load enable for the RF synthesizer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Two functions can fall in the same cycle: the `done` pulse that closes one transfer, and the acceptance of the next command. The bench provokes this by holding `cmd_valid` high with a second word while the first transfer runs. It then checks that the first transfer's `done` is seen while both enables are low, and that the new enable rises exactly one cycle later. The bench also checks that the second word arrives intact, with the correct target, phase timing and launch edges.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } ld_state_t;

  localparam int NUM_TARGETS = 2;
endpackage

// File: rtl/half_period_timer.sv
module half_period_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= load_word;
    else if (shift) sreg <= {sreg[WORD_W-2:0], 1'b0};
  end

  assign msb = sreg[WORD_W-1];

  // R2
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/dual_synth_loader.sv
module dual_synth_loader #(
  parameter int WORD_W   = 24,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_target,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              tgt_if_en,
  output logic              tgt_rf_en,
  output logic              busy,
  output logic              done
);
  import synth_loader_pkg::*;

  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  ld_state_t                state;
  logic                     sclk_q;
  logic                     done_q;
  logic [NUM_TARGETS-1:0]   en_q;
  logic [BW-1:0]            bits;
  logic                     tick;
  logic                     accept;
  logic                     shift;

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign shift     = (state == ST_HIGH) && tick;

  half_period_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (cmd_word),
    .shift     (shift),
    .msb       (ser_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      en_q   <= '0;
      bits   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOW;
          bits  <= '0;
          en_q  <= cmd_target ? 2'b10 : 2'b01;
        end
        ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (bits == LAST_BIT) begin
            state <= ST_TAIL;
          end else begin
            bits  <= bits + 1'b1;
            state <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          en_q   <= '0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk   = sclk_q;
  assign done      = done_q;
  assign tgt_if_en = en_q[0];
  assign tgt_rf_en = en_q[1];

  // R4
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_q));
  // R4
  en_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(en_q));
  // R2
  data_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> ($fell(sclk_q) || $rose(busy)));
  // R3
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> (en_q != '0));
  // R7
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((en_q == '0) && !busy));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: tb/dual_synth_loader_test.sv
`timescale 1ns/1ps
module dual_synth_loader_test;
  localparam int W = 24;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [W-1:0] cmd_word = '0;
  logic cmd_target = 1'b0;
  logic cmd_ready, ser_clk, ser_data, tgt_if_en, tgt_rf_en, busy, done;

  always #2.5 clk = ~clk;

  dual_synth_loader #(.WORD_W(W), .HALF_CYC(H)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_target(cmd_target), .ser_clk(ser_clk),
    .ser_data(ser_data), .tgt_if_en(tgt_if_en), .tgt_rf_en(tgt_rf_en),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] exp_word [0:63];
  bit           exp_tgt  [0:63];
  int nsent = 0;
  int nxfer = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit want_rf(input int idx);
    return exp_tgt[idx];
  endfunction

  // monitor
  int cyc = 0, last_chg = 0, last_rise = 0, start_cyc = 0, last_done_cyc = -10;
  int nbits = 0, b2b_seen = 0, idle_bad = 0;
  logic [W-1:0] cap;
  bit in_xfer = 0, tgt_rf = 0, data_bad = 0, phase_bad = 0, le_bad = 0, rdy_bad = 0;
  logic p_le = 0, p_sclk = 0, p_sdata = 0, p_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic le_any;
      cyc++;
      le_any = tgt_if_en | tgt_rf_en;
      if (tgt_if_en && tgt_rf_en) le_bad = 1;
      if (!le_any && (ser_clk || ser_data)) idle_bad++;
      if (le_any && !p_le) begin
        in_xfer = 1; cap = '0; nbits = 0; tgt_rf = tgt_rf_en; last_chg = cyc;
        data_bad = 0; phase_bad = 0; le_bad = 0; rdy_bad = 0; start_cyc = cyc;
        if (cyc - last_done_cyc == 1) b2b_seen++;
      end else if (in_xfer && le_any) begin
        if (ser_clk != p_sclk) begin
          if (cyc - last_chg != H) phase_bad = 1;
          last_chg = cyc;
          if (ser_clk) begin
            nbits++;
            cap = {cap[W-2:0], ser_data};
            last_rise = cyc;
          end
        end
        if ((ser_data != p_sdata) && !(p_sclk && !ser_clk)) data_bad = 1;
        if (tgt_rf_en != tgt_rf) le_bad = 1;
      end
      if (in_xfer && le_any && (cmd_ready || !busy)) rdy_bad = 1;
      if (done && p_done) chk(0, "R7 done width", 2, 1);
      if (done) begin
        chk(in_xfer, "R7 done without transfer", 0, 1);
        chk(!le_any && !busy, "R7 enable/busy low at done", {le_any, busy}, 0);
        chk(nbits == W, "R1 rising edge count", nbits, W);
        chk(cap == exp_word[nxfer], "R1 word shifted out", cap, exp_word[nxfer]);
        chk(tgt_rf == want_rf(nxfer), "R4 target select", tgt_rf, want_rf(nxfer));
        chk(!le_bad, "R4 enable steady and exclusive", le_bad, 0);
        chk(!data_bad, "R2 data launch edge", data_bad, 0);
        chk(!phase_bad, "R5 half-period length", phase_bad, 0);
        chk(cyc - last_rise == 2*H, "R6 enable tail", cyc - last_rise, 2*H);
        chk(!rdy_bad, "R8 ready low while busy", rdy_bad, 0);
        in_xfer = 0;
        nxfer++;
        last_done_cyc = cyc;
      end
      p_le = le_any; p_sclk = ser_clk; p_sdata = ser_data; p_done = done;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] w, input bit t);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_word = w; cmd_target = t;
    exp_word[nsent] = w; exp_tgt[nsent] = t; nsent++;
    @(negedge clk);
    cmd_valid = 0; cmd_word = W'($urandom); cmd_target = 1'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk({ser_clk, ser_data, tgt_if_en, tgt_rf_en, busy, done} == 6'b0, "R3 reset outputs",
        {ser_clk, ser_data, tgt_if_en, tgt_rf_en, busy, done}, 0);
    chk(cmd_ready == 1'b1, "R3 ready after reset", cmd_ready, 1);

    // directed corner words, R1 R4
    send(24'hFFFFFF, 1'b0); wait_idle();
    send(24'h000000, 1'b1); wait_idle();
    send(24'h800001, 1'b1); wait_idle();
    send(24'h555555, 1'b0); wait_idle();

    // R8: stray request while busy
    send(24'hA5C33C, 1'b0);
    repeat (7) @(negedge clk);
    chk(cmd_ready == 1'b0 && busy, "R8 ready low mid-transfer", cmd_ready, 0);
    cmd_valid = 1; cmd_word = 24'h5A3CC3; cmd_target = 1'b1;
    @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(nxfer == nsent, "R8 stray request ignored", nxfer, nsent);
    chk(!busy && !tgt_if_en && !tgt_rf_en, "R8 idle after stray request",
        {busy, tgt_if_en, tgt_rf_en}, 0);

    // R9: back-to-back with held valid
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_word = 24'h123456; cmd_target = 1'b1;
    exp_word[nsent] = 24'h123456; exp_tgt[nsent] = 1'b1; nsent++;
    @(negedge clk);
    cmd_word = 24'hFEDCBA; cmd_target = 1'b0;
    exp_word[nsent] = 24'hFEDCBA; exp_tgt[nsent] = 1'b0; nsent++;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(b2b_seen == 1, "R9 enable rises right after done", b2b_seen, 1);

    // random stimulus
    for (int i = 0; i < 12; i++) begin
      send(W'($urandom), 1'($urandom));
      wait_idle();
      repeat ($urandom % 5) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    chk(nxfer == nsent, "R8 transfer count", nxfer, nsent);
    chk(idle_bad == 0, "R3 lines low while idle", idle_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule